// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing frames from memory to a MAC-side byte stream. Software places a ring of three-word descriptors in memory and points the engine at the first one. Each descriptor carries a flags word, a word whose upper half is the frame length in bytes, and a word holding the buffer address. A one-cycle start pulse sets the run bit. The engine then reads the descriptor at the current ring position. If the descriptor is owned by hardware, the engine streams the buffer out byte by byte. It then writes the flags word back with the ownership bit cleared, so that software can poll for completion.

Each descriptor has an end-of-ring flag. When it is set, the engine's next position is the ring base. Otherwise the engine moves on by one descriptor (12 bytes). When the engine reads a descriptor that software has not handed over, it clears its own run bit and waits for another start pulse. Its position stays where it stopped. Buffers are read as 32-bit little-endian words and split into bytes. The final byte of each frame is marked.

Top module: `txring_dma`

## Requirements
- R1: While reset is asserted and right after it is released, `run_o`, `mem_req_o` and `tx_valid_o` are all low.
- R2: A pulse on `kick_i` makes `run_o` high on the following cycle. The first memory read after reset is word 0 of the descriptor at `ring_base_i`. Its three words are read at offsets 0, 4 and 8, in that order.
- R3: If bit 31 (owned) of a fetched flags word is 0, the engine drops `run_o` on the next cycle. It makes no write and sends no byte. The next start reads the same descriptor again.
- R4: If `kick_i` is high in the same cycle that the engine stops on an unowned descriptor, `run_o` stays high and the engine reads that descriptor again.
- R5: For a valid descriptor, the engine reads buffer words from the buffer address with its two low bits forced to zero, at increasing addresses. It sends exactly `length` bytes, lowest byte lane first. `tx_last_o` is high on the final byte only.
- R6: After a descriptor is handled, the engine makes exactly one write, to that descriptor's word 0. The data is the fetched flags word with bit 31 cleared and bit 27 holding the error status. Every other bit is unchanged. No byte is pending when the write is issued.
- R7: After a descriptor whose bit 30 (end of ring) is set, the next descriptor is read at `ring_base_i`. Otherwise it is read 12 bytes further on.
- R8: A descriptor is invalid if its frame-position field (bits 29:28) is not 2'b11 (whole frame) or its length is 0. For an invalid descriptor the engine sends no bytes and reads no buffer words. Its write-back has bit 27 set and bit 31 cleared.
- R9: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o`, `tx_data_o` and `tx_last_o` hold their values.
- R10: The engine has at most one read outstanding. It raises no request between a read's grant and the `mem_rvalid_i` that answers it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base_i | input | 32 | Byte address of the first descriptor |
| kick_i | input | 1 | Start request pulse; sets the run bit |
| run_o | output | 1 | Run bit: high while the engine is walking the ring |
| mem_req_o | output | 1 | Memory request, held until granted |
| mem_we_o | output | 1 | High for a write request, low for a read |
| mem_addr_o | output | 32 | Byte address of the request |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid, one pulse per read |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Byte available |
| tx_data_o | output | 8 | Byte value |
| tx_last_o | output | 1 | Final byte of the frame |
| tx_ready_i | input | 1 | Sink takes the byte this cycle |

## Verification
The start request and the engine's own stop can both land on the same clock edge. The bench provokes this with its memory model. It returns an unowned flags word for the ring base and raises `kick_i` in that same cycle, so the stop and the start meet on one edge. The bench then checks that `run_o` is still high after that edge. It also checks that its read log holds two fetches of the base descriptor before the engine finally stops.

// File: rtl/txring_pkg.sv
package txring_pkg;
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int DESC_WORDS = 3;
  localparam int DESC_BYTES = DESC_WORDS * WORD_BYTES;
  localparam int LEN_W      = 16;

  localparam int BIT_OWN    = 31;
  localparam int BIT_EOR    = 30;
  localparam int BIT_POS_HI = 29;
  localparam int BIT_POS_LO = 28;
  localparam int BIT_ERR    = 27;
  localparam logic [1:0] POS_WHOLE = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FLAGS, ST_LEN, ST_PTR, ST_FETCH, ST_DRAIN, ST_BACK
  } ring_state_t;

  function automatic logic [WORD_W-1:0] step_offset(
      input logic [WORD_W-1:0] off, input logic end_of_ring);
    return end_of_ring ? '0 : off + WORD_W'(DESC_BYTES);
  endfunction

  function automatic logic [2:0] lanes_now(input logic [LEN_W-1:0] left);
    return (left >= LEN_W'(WORD_BYTES)) ? 3'(WORD_BYTES) : left[2:0];
  endfunction

  function automatic logic frame_usable(input logic [WORD_W-1:0] flags,
                                        input logic [LEN_W-1:0] len);
    return (flags[BIT_POS_HI:BIT_POS_LO] == POS_WHOLE) && (len != '0);
  endfunction

  function automatic logic [WORD_W-1:0] retire_flags(
      input logic [WORD_W-1:0] flags, input logic failed);
    logic [WORD_W-1:0] r;
    r = flags;
    r[BIT_OWN] = 1'b0;
    r[BIT_ERR] = failed;
    return r;
  endfunction
endpackage

// File: rtl/txring_runbit.sv
module txring_runbit (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  input  logic stop_i,
  output logic run_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      run_o <= 1'b0;
    else if (kick_i) run_o <= 1'b1;
    else if (stop_i) run_o <= 1'b0;
  end
endmodule

// File: rtl/txring_serial.sv
module txring_serial #(
  parameter int LANES = 4,
  parameter int CW    = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [LANES*8-1:0] word_i,
  input  logic [CW-1:0]      count_i,
  input  logic               final_i,
  output logic               busy_o,
  output logic               tx_valid_o,
  output logic [7:0]         tx_data_o,
  output logic               tx_last_o,
  input  logic               tx_ready_i
);
  logic [LANES*8-1:0] shreg;
  logic [CW-1:0]      left;
  logic               fin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
      fin   <= 1'b0;
    end else if (load_i) begin
      shreg <= word_i;
      left  <= count_i;
      fin   <= final_i;
    end else if (tx_valid_o && tx_ready_i) begin
      shreg <= shreg >> 8;
      left  <= left - CW'(1);
    end
  end

  assign busy_o     = (left != '0);
  assign tx_valid_o = busy_o;
  assign tx_data_o  = shreg[7:0];
  assign tx_last_o  = fin && (left == CW'(1));
endmodule

// File: rtl/txring_seq.sv
module txring_seq
  import txring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] ring_base_i,
  input  logic              run_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              ser_load_o,
  output logic [WORD_W-1:0] ser_word_o,
  output logic [2:0]        ser_count_o,
  output logic              ser_final_o,
  input  logic              ser_busy_i,
  output logic              stop_o,
  output logic              retire_o
);
  ring_state_t       st;
  logic              pend;
  logic [WORD_W-1:0] off, flags, buf_ptr;
  logic [LEN_W-1:0]  len, left;
  logic              failed;

  logic [WORD_W-1:0] desc_addr;
  logic              accept, rd_back;

  assign desc_addr = ring_base_i + off;
  assign accept    = mem_req_o && mem_gnt_i;
  assign rd_back   = pend && mem_rvalid_i;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = desc_addr;
    mem_wdata_o = retire_flags(flags, failed);
    unique case (st)
      ST_FLAGS: mem_req_o = !pend;
      ST_LEN: begin
        mem_req_o  = !pend;
        mem_addr_o = desc_addr + WORD_W'(WORD_BYTES);
      end
      ST_PTR: begin
        mem_req_o  = !pend;
        mem_addr_o = desc_addr + WORD_W'(2 * WORD_BYTES);
      end
      ST_FETCH: begin
        mem_req_o  = !pend;
        mem_addr_o = buf_ptr;
      end
      ST_BACK: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
      end
      default: ;
    endcase
  end

  assign stop_o      = (st == ST_FLAGS) && rd_back && !mem_rdata_i[BIT_OWN];
  assign retire_o    = (st == ST_BACK) && accept;
  assign ser_load_o  = (st == ST_FETCH) && rd_back;
  assign ser_word_o  = mem_rdata_i;
  assign ser_count_o = lanes_now(left);
  assign ser_final_o = (left <= LEN_W'(WORD_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      pend    <= 1'b0;
      off     <= '0;
      flags   <= '0;
      buf_ptr <= '0;
      len     <= '0;
      left    <= '0;
      failed  <= 1'b0;
    end else begin
      if (accept && !mem_we_o) pend <= 1'b1;
      else if (rd_back)        pend <= 1'b0;

      unique case (st)
        ST_IDLE: if (run_i) st <= ST_FLAGS;
        ST_FLAGS: if (rd_back) begin
          flags <= mem_rdata_i;
          st    <= mem_rdata_i[BIT_OWN] ? ST_LEN : ST_IDLE;
        end
        ST_LEN: if (rd_back) begin
          len <= mem_rdata_i[WORD_W-1 -: LEN_W];
          st  <= ST_PTR;
        end
        ST_PTR: if (rd_back) begin
          buf_ptr <= {mem_rdata_i[WORD_W-1:2], 2'b00};
          left    <= len;
          failed  <= !frame_usable(flags, len);
          st      <= frame_usable(flags, len) ? ST_FETCH : ST_BACK;
        end
        ST_FETCH: if (rd_back) begin
          left    <= left - LEN_W'(lanes_now(left));
          buf_ptr <= buf_ptr + WORD_W'(WORD_BYTES);
          st      <= ST_DRAIN;
        end
        ST_DRAIN: if (!ser_busy_i) st <= (left == '0) ? ST_BACK : ST_FETCH;
        ST_BACK: if (accept) begin
          off <= step_offset(off, flags[BIT_EOR]);
          st  <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txring_dma.sv
module txring_dma
  import txring_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ring_base_i,
  input  logic        kick_i,
  output logic        run_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_gnt_i,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_last_o,
  input  logic        tx_ready_i
);
  logic              stop_evt;
  logic              retire_evt;
  logic              ser_load;
  logic [WORD_W-1:0] ser_word;
  logic [2:0]        ser_count;
  logic              ser_final;
  logic              ser_busy;

  txring_runbit u_run (
    .clk(clk), .rst_n(rst_n), .kick_i(kick_i), .stop_i(stop_evt), .run_o(run_o)
  );

  txring_seq u_seq (
    .clk(clk), .rst_n(rst_n), .ring_base_i(ring_base_i), .run_i(run_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_gnt_i(mem_gnt_i), .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i(mem_rdata_i), .ser_load_o(ser_load), .ser_word_o(ser_word),
    .ser_count_o(ser_count), .ser_final_o(ser_final), .ser_busy_i(ser_busy),
    .stop_o(stop_evt), .retire_o(retire_evt)
  );

  txring_serial #(.LANES(WORD_BYTES), .CW(3)) u_ser (
    .clk(clk), .rst_n(rst_n), .load_i(ser_load), .word_i(ser_word),
    .count_i(ser_count), .final_i(ser_final), .busy_o(ser_busy),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_last_o(tx_last_o),
    .tx_ready_i(tx_ready_i)
  );
endmodule

// File: rtl/txring_dma_chk.sv
module txring_dma_chk
  import txring_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        kick_i,
  input logic        run_o,
  input logic        stop_evt,
  input logic        retire_evt,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic        mem_gnt_i,
  input logic        mem_rvalid_i,
  input logic [31:0] mem_wdata_o,
  input logic        tx_valid_o,
  input logic        tx_ready_i,
  input logic [7:0]  tx_data_o,
  input logic        tx_last_o
);
  logic [1:0] in_flight;
  always_ff @(posedge clk) begin
    if (!rst_n) in_flight <= '0;
    else in_flight <= in_flight + 2'(mem_req_o && mem_gnt_i && !mem_we_o)
                                - 2'(mem_rvalid_i);
  end

  assert_one_read_in_flight_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> in_flight == 2'd0);
  assert_rvalid_answers_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid_i |-> in_flight == 2'd1);
  assert_hold_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));
  assert_kick_sets_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> run_o);
  assert_stop_drops_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt && !kick_i |=> !run_o);
  assert_writeback_unowned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> !mem_wdata_o[BIT_OWN]);
  assert_retire_drained_R6: assert property (@(posedge clk) disable iff (!rst_n)
    retire_evt |-> !tx_valid_o);
  assert_gap_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o && tx_ready_i && tx_last_o |=> !tx_valid_o);
endmodule

bind txring_dma txring_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .kick_i(kick_i), .run_o(run_o),
  .stop_evt(stop_evt), .retire_evt(retire_evt),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_gnt_i(mem_gnt_i),
  .mem_rvalid_i(mem_rvalid_i), .mem_wdata_o(mem_wdata_o),
  .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
  .tx_data_o(tx_data_o), .tx_last_o(tx_last_o)
);

// File: tb/test_txring_dma.sv
`timescale 1ns/1ps
module test_txring_dma;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [31:0] ring_base = 32'h100;
  logic        kick = 1'b0;
  logic        run_o, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        tx_valid, tx_last;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;

  txring_dma i_txring_dma (
    .clk(clk), .rst_n(rst_n), .ring_base_i(ring_base), .kick_i(kick), .run_o(run_o),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .tx_last_o(tx_last), .tx_ready_i(tx_ready)
  );

  int vectors = 0, miscompares = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] rd_log [0:511];
  logic [31:0] wr_addr_log [0:63];
  logic [31:0] wr_data_log [0:63];
  logic [7:0]  byte_log [0:1023];
  logic        last_log [0:1023];
  int rd_n = 0, wr_n = 0, by_n = 0;
  bit kick_req = 0, arm_kick = 0, kick_hit = 0;
  bit rd_pend = 0;
  logic [31:0] rd_addr = '0;
  bit stall_prev = 0;
  logic [7:0] stall_data = '0;
  logic stall_last = 1'b0;
  int gnt_pct = 100, rdy_pct = 100;

  logic [31:0] d_flags [0:7];
  logic [15:0] d_len [0:7];
  logic [31:0] d_ptr [0:7];
  int d_n = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    logic [31:0] w;
    w = mem[a[11:2]];
    return w[8*a[1:0] +: 8];
  endfunction

  function automatic logic [31:0] expect_retire(input logic [31:0] f, input bit bad);
    return {1'b0, f[30:28], bad, f[26:0]};
  endfunction

  // memory, sink and start-pulse model, all driven at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_gnt = 0; mem_rvalid = 0; tx_ready = 0; kick = 0; rd_pend = 0; stall_prev = 0;
    end else begin
      kick = kick_req;
      kick_req = 0;
      if (rd_pend) chk(!mem_req, "R10", {63'd0, mem_req}, 64'd0);
      mem_rvalid = rd_pend;
      mem_rdata = rd_pend ? mem[rd_addr[11:2]] : 32'h0;
      if (rd_pend && arm_kick && !mem_rdata[31] && rd_addr == ring_base) begin
        kick = 1; arm_kick = 0; kick_hit = 1;
      end
      rd_pend = 0;
      if (stall_prev)
        chk(tx_valid && tx_data == stall_data && tx_last == stall_last, "R9",
            {54'd0, tx_valid, tx_last, tx_data}, {54'd0, 1'b1, stall_last, stall_data});
      mem_gnt = ($urandom_range(99) < gnt_pct);
      tx_ready = ($urandom_range(99) < rdy_pct);
      if (mem_req && mem_gnt) begin
        if (mem_we) begin
          mem[mem_addr[11:2]] = mem_wdata;
          if (wr_n < 64) begin wr_addr_log[wr_n] = mem_addr; wr_data_log[wr_n] = mem_wdata; end
          wr_n++;
        end else begin
          rd_pend = 1; rd_addr = mem_addr;
          if (rd_n < 512) rd_log[rd_n] = mem_addr;
          rd_n++;
        end
      end
      if (tx_valid && tx_ready) begin
        if (by_n < 1024) begin byte_log[by_n] = tx_data; last_log[by_n] = tx_last; end
        by_n++;
      end
      stall_prev = tx_valid && !tx_ready;
      stall_data = tx_data;
      stall_last = tx_last;
    end
  end

  task automatic clear_logs();
    rd_n = 0; wr_n = 0; by_n = 0;
  endtask

  task automatic kick_and_wait(input string tag);
    clear_logs();
    kick_req = 1;
    @(negedge clk);
    @(posedge clk); #1;
    chk(run_o, "R2", {63'd0, run_o}, 64'd1);
    for (int c = 0; c < 20000 && run_o; c++) begin @(posedge clk); #1; end
    chk(!run_o, {"R2 watchdog ", tag}, {63'd0, run_o}, 64'd0);
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic load_ring();
    for (int i = 0; i < d_n; i++) begin
      logic [31:0] d;
      d = ring_base + 32'(12 * i);
      mem[d[11:2]] = d_flags[i];
      mem[d[11:2] + 10'd1] = {d_len[i], 16'($urandom)};
      mem[d[11:2] + 10'd2] = d_ptr[i];
      for (int w = 0; w < 16; w++) mem[10'h100 + 10'(16 * i + w)] = $urandom;
    end
  endtask

  task automatic check_round(input string tag);
    int er, eb;
    er = 0; eb = 0;
    for (int i = 0; i < d_n; i++) begin
      logic [31:0] d, p;
      bit good;
      d = ring_base + 32'(12 * i);
      good = (d_flags[i][29:28] == 2'b11) && (d_len[i] != 0);
      for (int k = 0; k < 3; k++) begin
        chk(er < rd_n && rd_log[er] == d + 32'(4 * k), (i == 0) ? "R2" : "R7",
            {32'd0, rd_log[er]}, {32'd0, d + 32'(4 * k)});
        er++;
      end
      p = {d_ptr[i][31:2], 2'b00};
      if (good) begin
        for (int w = 0; w < (int'(d_len[i]) + 3) / 4; w++) begin
          chk(er < rd_n && rd_log[er] == p + 32'(4 * w), "R5",
              {32'd0, rd_log[er]}, {32'd0, p + 32'(4 * w)});
          er++;
        end
        for (int k = 0; k < int'(d_len[i]); k++) begin
          logic [7:0] eb_val;
          eb_val = mem_byte(p + 32'(k));
          chk(eb < by_n && byte_log[eb] == eb_val && last_log[eb] == (k == int'(d_len[i]) - 1),
              "R5", {55'd0, last_log[eb], byte_log[eb]},
              {55'd0, k == int'(d_len[i]) - 1, eb_val});
          eb++;
        end
      end
      chk(i < wr_n && wr_addr_log[i] == d && wr_data_log[i] == expect_retire(d_flags[i], !good),
          good ? "R6" : "R8", {wr_addr_log[i], wr_data_log[i]},
          {d, expect_retire(d_flags[i], !good)});
    end
    chk(er < rd_n && rd_log[er] == ring_base, {"R7 wrap ", tag}, {32'd0, rd_log[er]},
        {32'd0, ring_base});
    er++;
    chk(rd_n == er, "R7", 64'(rd_n), 64'(er));
    chk(by_n == eb, "R5", 64'(by_n), 64'(eb));
    chk(wr_n == d_n, "R6", 64'(wr_n), 64'(d_n));
  endtask

  initial begin
    void'($urandom(32'd7341));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (5) @(posedge clk);
    #1;
    chk(!run_o && !mem_req && !tx_valid, "R1", {61'd0, run_o, mem_req, tx_valid}, 64'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!run_o && !mem_req && !tx_valid, "R1", {61'd0, run_o, mem_req, tx_valid}, 64'd0);

    // R3: unowned descriptor at the base stops the engine untouched
    mem[ring_base[11:2]] = 32'h7000_1234;
    kick_and_wait("R3");
    chk(rd_n == 1 && rd_log[0] == ring_base, "R3", {32'(rd_n), rd_log[0]}, {32'd1, ring_base});
    chk(wr_n == 0 && by_n == 0, "R3", {32'(wr_n), 32'(by_n)}, 64'd0);

    // R4: start pulse in the very cycle of the self-stop
    arm_kick = 1; kick_hit = 0;
    clear_logs();
    kick_req = 1;
    for (int c = 0; c < 200 && !kick_hit; c++) @(posedge clk);
    #1;
    chk(kick_hit && run_o, "R4", {62'd0, kick_hit, run_o}, 64'd3);
    for (int c = 0; c < 200 && run_o; c++) begin @(posedge clk); #1; end
    chk(rd_n == 2 && rd_log[0] == ring_base && rd_log[1] == ring_base, "R4",
        64'(rd_n), 64'd2);
    chk(wr_n == 0 && by_n == 0, "R3", {32'(wr_n), 32'(by_n)}, 64'd0);

    // directed ring: word-exact, single byte and misaligned pointers
    d_n = 3;
    d_flags[0] = 32'hB000_0011; d_len[0] = 16'd4; d_ptr[0] = 32'h400;
    d_flags[1] = 32'hB800_0022; d_len[1] = 16'd1; d_ptr[1] = 32'h443;
    d_flags[2] = 32'hF000_0033; d_len[2] = 16'd7; d_ptr[2] = 32'h481;
    load_ring();
    kick_and_wait("directed");
    check_round("directed");

    // directed: single descriptor that ends the ring at once, plus stalls
    gnt_pct = 50; rdy_pct = 40;
    d_n = 1;
    d_flags[0] = 32'hF000_ABCD; d_len[0] = 16'd9; d_ptr[0] = 32'h402;
    load_ring();
    kick_and_wait("single");
    check_round("single");

    // random rings
    for (int r = 0; r < 10; r++) begin
      gnt_pct = 40 + int'($urandom_range(60));
      rdy_pct = 30 + int'($urandom_range(70));
      ring_base = 32'h100 + 32'(16 * $urandom_range(15));
      d_n = 1 + int'($urandom_range(4));
      for (int i = 0; i < d_n; i++) begin
        int sel;
        logic [1:0] pos;
        sel = int'($urandom_range(7));
        pos = (sel == 0) ? 2'b10 : 2'b11;
        d_len[i] = (sel == 1) ? 16'd0 : 16'(1 + $urandom_range(39));
        d_flags[i] = {1'b1, i == d_n - 1, pos, 1'($urandom), 27'($urandom)};
        d_ptr[i] = 32'h400 + 32'(64 * i) + 32'($urandom_range(3));
      end
      load_ring();
      kick_and_wait("random");
      check_round("random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #800000;
    miscompares++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule